// File: doc/BRIEF.md
# Linked Command Descriptor Fetcher

This block walks a linked list of transfer descriptors held in system memory for a serial flash controller. Software writes the address of the first descriptor to the start port. The block reads three 32-bit words per descriptor over a single-outstanding memory read port. It checks and decodes them, then hands one transfer command (direction, lane count, keep-select flag, byte length, buffer address) to the serial shift engine. It waits for that engine to report completion before moving on.

After each completion the block follows the descriptor's link word. A zero link ends the walk and raises the chain-done interrupt. A misaligned buffer, a read length that is not a whole number of words, or an error response on a fetch stops the walk early and raises a matching interrupt flag instead. While the walk runs, the address of the descriptor in progress and the buffer address of the last issued command are visible on output ports.

Top module: `cmd_chain_walker`

## Requirements
- R1: After reset, busy, mem_req and cmd_valid are low, and irq_status, irq, cur_desc_addr and cur_mem_addr are zero.
- R2: A start with a nonzero address fetches the descriptor's three words in the order address, address+4, address+8. Each is a request on mem_req that holds mem_addr steady until mem_rvalid. Word 0 is the buffer address, word 1 the link address, word 2 the control word.
- R3: The control word is decoded with direction at bit 0 (0 = read, 1 = write), lane mode at bits 3:1 (1 single, 2 dual, 3 quad), keep-select flag at bit 8 and byte length at bits 31:16. The command is presented on the cmd_* ports with a cmd_valid pulse one cycle long.
- R4: After issuing a command the block makes no memory request until cmd_done is seen. busy stays high during this wait.
- R5: A nonzero link address makes the block fetch the next descriptor from that address after cmd_done. The issued keep-select flag is forced to 1 whenever the link is nonzero.
- R6: cmd_done on a descriptor whose link is zero sets irq_status bit 31 (chain done) and drops busy.
- R7: A start with address zero sets chain done at once and makes no memory request.
- R8: A buffer address with any of its low 5 bits set sets irq_status bit 1 (descriptor error), ends the walk and issues no command.
- R9: A read descriptor whose length is not a multiple of 4 is treated like R8. A write descriptor of any length is issued.
- R10: An error response (mem_rerr with mem_rvalid) during a fetch sets irq_status bit 3 (bus error), ends the walk and issues no command.
- R11: cur_desc_addr holds the address of the descriptor being fetched or executed. cur_mem_addr holds the buffer address of the last issued command.
- R12: A start while busy is ignored. A start accepted when idle clears all irq_status flags, and at most one of bits 31, 3 and 1 is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the first-descriptor address |
| start_addr | input | AW | Address of the first descriptor |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_dir | output | 1 | 0 read, 1 write |
| cmd_lanes | output | 3 | Lane mode code |
| cmd_frag | output | 1 | Keep chip select asserted after this command |
| cmd_len | output | 16 | Byte count |
| cmd_addr | output | AW | Data buffer address |
| cmd_done | input | 1 | Shift engine finished the issued command |
| cur_desc_addr | output | AW | Descriptor in progress |
| cur_mem_addr | output | AW | Buffer of the last issued command |
| busy | output | 1 | Walk in progress |
| irq_status | output | 32 | Sticky flags: bit 31 done, bit 3 bus error, bit 1 descriptor error |
| irq | output | 1 | OR of irq_status |

## Verification
The bench builds the block with AW = 32 and ALIGN_BITS = 5. A memory model of 64 words then covers every descriptor it places, and a buffer offset of 0x10 or 0x01 lands on the alignment check. The 16-bit length field reaches its top value 0xFFFC without any wide counter. A single-word error injection address puts the bus-error abort on the middle word of a fetch.

// File: rtl/cwk_pkg.sv
package cwk_pkg;
  localparam int WORD_W     = 32;
  localparam int DIR_BIT    = 0;
  localparam int LANE_LO    = 1;
  localparam int LANE_HI    = 3;
  localparam int FRAG_BIT   = 8;
  localparam int LEN_LO     = 16;
  localparam int LEN_HI     = 31;
  localparam int LEN_W      = LEN_HI - LEN_LO + 1;
  localparam int IRQ_DONE   = 31;
  localparam int IRQ_BUS    = 3;
  localparam int IRQ_DESC   = 1;
  localparam int DESC_WORDS = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WAIT
  } walk_st_t;

  typedef struct packed {
    logic             dir;
    logic [2:0]       lanes;
    logic             frag;
    logic [LEN_W-1:0] len;
  } cmd_t;
endpackage

// File: rtl/cwk_word_capture.sv
module cwk_word_capture
  import cwk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              load,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] data,
  output logic [AW-1:0]     buf_addr,
  output logic [AW-1:0]     link_addr,
  output logic [WORD_W-1:0] ctrl
);
  // small RAM-style store, no reset needed: every word is written before use
  logic [WORD_W-1:0] words [DESC_WORDS];

  always_ff @(posedge clk) begin
    if (load && (idx < 2'(DESC_WORDS))) begin
      words[idx] <= data;
    end
  end

  assign buf_addr  = words[0][AW-1:0];
  assign link_addr = words[1][AW-1:0];
  assign ctrl      = words[2];
endmodule

// File: rtl/cwk_desc_decode.sv
module cwk_desc_decode
  import cwk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic [AW-1:0]     buf_addr,
  input  logic [AW-1:0]     link_addr,
  input  logic [WORD_W-1:0] ctrl,
  output cmd_t              cmd,
  output logic              chain_end,
  output logic              bad_align,
  output logic              bad_len
);
  always_comb begin
    chain_end = (link_addr == '0);
    cmd.dir   = ctrl[DIR_BIT];
    cmd.lanes = ctrl[LANE_HI:LANE_LO];
    cmd.len   = ctrl[LEN_HI:LEN_LO];
    // any descriptor that links onward must keep the select asserted
    cmd.frag  = ctrl[FRAG_BIT] | ~chain_end;
    bad_align = |buf_addr[ALIGN_BITS-1:0];
    bad_len   = (ctrl[DIR_BIT] == 1'b0) && (|ctrl[LEN_LO+1:LEN_LO]);
  end
endmodule

// File: rtl/cmd_chain_walker.sv
module cmd_chain_walker
  import cwk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic [AW-1:0]     start_addr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              cmd_valid,
  output logic              cmd_dir,
  output logic [2:0]        cmd_lanes,
  output logic              cmd_frag,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [AW-1:0]     cmd_addr,
  input  logic              cmd_done,
  output logic [AW-1:0]     cur_desc_addr,
  output logic [AW-1:0]     cur_mem_addr,
  output logic              busy,
  output logic [31:0]       irq_status,
  output logic              irq
);
  localparam logic [1:0]    LAST_IDX = 2'(DESC_WORDS - 1);
  localparam logic [AW-1:0] WORD_STEP = AW'(WORD_W / 8);

  walk_st_t          st_q;
  logic [1:0]        widx_q;
  logic              cap_load;
  logic [AW-1:0]     w_buf, w_link;
  logic [WORD_W-1:0] w_ctrl;
  cmd_t              dec_cmd;
  logic              dec_end, dec_align, dec_len;

  assign cap_load = (st_q == ST_FETCH) && mem_rvalid && !mem_rerr;

  cwk_word_capture #(.AW(AW)) u_capture (
    .clk       (clk),
    .load      (cap_load),
    .idx       (widx_q),
    .data      (mem_rdata),
    .buf_addr  (w_buf),
    .link_addr (w_link),
    .ctrl      (w_ctrl)
  );

  cwk_desc_decode #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) u_decode (
    .buf_addr  (w_buf),
    .link_addr (w_link),
    .ctrl      (w_ctrl),
    .cmd       (dec_cmd),
    .chain_end (dec_end),
    .bad_align (dec_align),
    .bad_len   (dec_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      widx_q        <= '0;
      mem_req       <= 1'b0;
      mem_addr      <= '0;
      cmd_valid     <= 1'b0;
      cmd_dir       <= 1'b0;
      cmd_lanes     <= '0;
      cmd_frag      <= 1'b0;
      cmd_len       <= '0;
      cmd_addr      <= '0;
      cur_desc_addr <= '0;
      cur_mem_addr  <= '0;
      busy          <= 1'b0;
      irq_status    <= '0;
    end else begin
      cmd_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_wr) begin
            irq_status <= '0;
            if (start_addr == '0) begin
              irq_status[IRQ_DONE] <= 1'b1;
            end else begin
              st_q          <= ST_FETCH;
              cur_desc_addr <= start_addr;
              mem_addr      <= start_addr;
              mem_req       <= 1'b1;
              widx_q        <= '0;
              busy          <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            if (mem_rerr) begin
              mem_req             <= 1'b0;
              busy                <= 1'b0;
              irq_status[IRQ_BUS] <= 1'b1;
              st_q                <= ST_IDLE;
            end else if (widx_q == LAST_IDX) begin
              mem_req <= 1'b0;
              st_q    <= ST_CHECK;
            end else begin
              widx_q   <= widx_q + 2'd1;
              mem_addr <= mem_addr + WORD_STEP;
            end
          end
        end
        ST_CHECK: begin
          if (dec_align || dec_len) begin
            irq_status[IRQ_DESC] <= 1'b1;
            busy                 <= 1'b0;
            st_q                 <= ST_IDLE;
          end else begin
            cmd_valid    <= 1'b1;
            cmd_dir      <= dec_cmd.dir;
            cmd_lanes    <= dec_cmd.lanes;
            cmd_frag     <= dec_cmd.frag;
            cmd_len      <= dec_cmd.len;
            cmd_addr     <= w_buf;
            cur_mem_addr <= w_buf;
            st_q         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cmd_done && !cmd_valid) begin
            if (dec_end) begin
              irq_status[IRQ_DONE] <= 1'b1;
              busy                 <= 1'b0;
              st_q                 <= ST_IDLE;
            end else begin
              cur_desc_addr <= w_link;
              mem_addr      <= w_link;
              mem_req       <= 1'b1;
              widx_q        <= '0;
              st_q          <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq = |irq_status;
endmodule

// File: rtl/cwk_checker.sv
module cwk_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          mem_rerr,
  input logic          cmd_valid,
  input logic          busy,
  input logic [31:0]   irq_status
);
  // R2: a pending request keeps its address until answered
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R3: command pulse lasts one cycle
  a_r3_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R4: no fetch while a command is outstanding
  a_r4_no_fetch_on_issue: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !mem_req);

  // R6: chain done only when the walk has stopped
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[31]) |-> !busy);

  // R10: error response ends the fetch and flags a bus error
  a_r10_bus_abort: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid && mem_rerr) |=> (!mem_req && irq_status[3]));

  // R12: outcome flags are mutually exclusive
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_status[31], irq_status[3], irq_status[1]}));
endmodule

bind cmd_chain_walker cwk_checker #(.AW(AW)) i_cwk_checker (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .mem_rerr   (mem_rerr),
  .cmd_valid  (cmd_valid),
  .busy       (busy),
  .irq_status (irq_status)
);

// File: tb/test_cmd_chain_walker.sv
module test_cmd_chain_walker;
  localparam int AW = 32;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_wr;
  logic [AW-1:0] start_addr;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [31:0]   mem_rdata;
  logic          mem_rerr;
  logic          cmd_valid, cmd_dir, cmd_frag, cmd_done, busy, irq;
  logic [2:0]    cmd_lanes;
  logic [15:0]   cmd_len;
  logic [AW-1:0] cmd_addr, cur_desc_addr, cur_mem_addr;
  logic [31:0]   irq_status;

  always #4 clk = ~clk;

  cmd_chain_walker #(.AW(AW), .ALIGN_BITS(5)) i_cmd_chain_walker (.*);

  // memory model: 64 words, one response per request, optional error word
  logic [31:0] mem [64];
  logic [31:0] err_addr;
  logic [31:0] rd_log [8];
  int          rd_n;

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rerr   <= mem_req && !mem_rvalid && (mem_addr == err_addr);
      mem_rdata  <= mem[mem_addr[7:2]];
      if (mem_req && !mem_rvalid) begin
        if (rd_n < 8) rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] b, input logic [31:0] link,
                          input logic [31:0] ctrl);
    mem[at/4]     = b;
    mem[at/4 + 1] = link;
    mem[at/4 + 2] = ctrl;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    start_addr = a;
    start_wr   = 1'b1;
    @(negedge clk);
    start_wr   = 1'b0;
  endtask

  // waits for a command pulse or the end of the walk
  task automatic wait_cmd(output bit got);
    got = 0;
    for (int i = 0; i < 100; i++) begin
      if (cmd_valid) begin got = 1; return; end
      if (!busy) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_cmd(input int hold);
    repeat (hold) @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
  endtask

  // vector: buffer, control word, expect descriptor error, expected issued frag
  typedef struct packed {
    logic [31:0] b;
    logic [31:0] ctrl;
    logic        bad;
    logic        frag;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h0005_0003, 1'b0, 1'b0},  // write single len 5
    '{32'h0000_2000, 32'h0040_0106, 1'b0, 1'b1},  // read quad len 64 frag
    '{32'h0000_3020, 32'h0008_0004, 1'b0, 1'b0},  // read dual len 8
    '{32'h0000_3010, 32'h0004_0003, 1'b1, 1'b0},  // misaligned by 0x10
    '{32'h0000_4000, 32'h0006_0002, 1'b1, 1'b0},  // read len 6
    '{32'h0000_5000, 32'h0007_0007, 1'b0, 1'b0},  // write quad len 7
    '{32'h0000_6001, 32'h0004_0002, 1'b1, 1'b0},  // misaligned by 1
    '{32'h0000_FFE0, 32'hFFFC_0006, 1'b0, 1'b0}   // read quad len 0xFFFC
  };

  task automatic run_all();
    bit got;
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1 irq_status", irq_status, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 cur_desc_addr", cur_desc_addr, 32'd0);
    chk("R1 cur_mem_addr", cur_mem_addr, 32'd0);

    // table walk: single descriptors at 0x40
    for (int v = 0; v < NV; v++) begin
      put_desc(32'h40, VECS[v].b, 32'd0, VECS[v].ctrl);
      kick(32'h40);
      wait_cmd(got);
      if (VECS[v].bad) begin
        chk("R8 R9 no command", {31'd0, got}, 32'd0);
        wait_idle();
        chk("R8 R9 desc error flag", irq_status, 32'h0000_0002);
      end else begin
        chk("R3 issued", {31'd0, got}, 32'd1);
        chk("R3 dir", {31'd0, cmd_dir}, {31'd0, VECS[v].ctrl[0]});
        chk("R3 lanes", {29'd0, cmd_lanes}, {29'd0, VECS[v].ctrl[3:1]});
        chk("R3 frag", {31'd0, cmd_frag}, {31'd0, VECS[v].frag});
        chk("R3 len", {16'd0, cmd_len}, {16'd0, VECS[v].ctrl[31:16]});
        chk("R3 addr", cmd_addr, VECS[v].b);
        chk("R11 cur_mem_addr", cur_mem_addr, VECS[v].b);
        chk("R11 cur_desc_addr", cur_desc_addr, 32'h40);
        @(negedge clk);
        chk("R3 pulse ends", {31'd0, cmd_valid}, 32'd0);
        finish_cmd(2);
        wait_idle();
        chk("R6 chain done", irq_status, 32'h8000_0000);
        chk("R6 irq line", {31'd0, irq}, 32'd1);
      end
    end

    // R7 zero start
    rd_n = 0;
    kick(32'd0);
    @(negedge clk);
    chk("R7 done at once", irq_status, 32'h8000_0000);
    chk("R7 not busy", {31'd0, busy}, 32'd0);
    chk("R7 no fetch", rd_n, 0);

    // R2 R4 R5 R11 two-link chain
    put_desc(32'h80, 32'h7000, 32'hC0, 32'h0004_0003);
    put_desc(32'hC0, 32'h7100, 32'h00, 32'h0008_0004);
    rd_n = 0;
    kick(32'h80);
    wait_cmd(got);
    chk("R5 first issued", {31'd0, got}, 32'd1);
    chk("R2 fetch order w0", rd_log[0], 32'h80);
    chk("R2 fetch order w1", rd_log[1], 32'h84);
    chk("R2 fetch order w2", rd_log[2], 32'h88);
    chk("R5 forced frag", {31'd0, cmd_frag}, 32'd1);
    chk("R11 desc A", cur_desc_addr, 32'h80);
    repeat (5) @(negedge clk);
    chk("R4 no request while waiting", {31'd0, mem_req}, 32'd0);
    chk("R4 busy while waiting", {31'd0, busy}, 32'd1);
    chk("R4 no extra reads", rd_n, 3);
    finish_cmd(0);
    wait_cmd(got);
    chk("R5 second issued", {31'd0, got}, 32'd1);
    chk("R5 link followed", rd_log[3], 32'hC0);
    chk("R11 desc B", cur_desc_addr, 32'hC0);
    chk("R11 buffer B", cur_mem_addr, 32'h7100);
    chk("R5 last frag clear", {31'd0, cmd_frag}, 32'd0);
    chk("R5 no done yet", irq_status, 32'd0);
    finish_cmd(1);
    wait_idle();
    chk("R6 chain of two done", irq_status, 32'h8000_0000);

    // R10 error on the middle word
    put_desc(32'h20, 32'h1000, 32'd0, 32'h0004_0003);
    err_addr = 32'h24;
    kick(32'h20);
    wait_cmd(got);
    chk("R10 no command", {31'd0, got}, 32'd0);
    chk("R10 bus error flag", irq_status, 32'h0000_0008);
    chk("R10 not busy", {31'd0, busy}, 32'd0);
    err_addr = 32'hFFFF_FFFF;

    // R12 start while busy ignored, flags cleared on accepted start
    put_desc(32'h40, 32'h2000, 32'd0, 32'h0004_0003);
    kick(32'h40);
    chk("R12 old flags cleared", irq_status, 32'd0);
    wait_cmd(got);
    kick(32'h80);
    chk("R12 busy start ignored", cur_desc_addr, 32'h40);
    chk("R12 still busy", {31'd0, busy}, 32'd1);
    finish_cmd(0);
    wait_idle();
    chk("R12 only done set", irq_status, 32'h8000_0000);
  endtask

  initial begin
    rst        = 1'b1;
    start_wr   = 1'b0;
    start_addr = '0;
    cmd_done   = 1'b0;
    err_addr   = 32'hFFFF_FFFF;
    rd_n       = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule